// File: doc/BRIEF.md
# Bresenham Line Pixel Datapath

This block is the arithmetic core of a hardware line drawer. A sequencer outside the block opens a line with a start strobe. With that strobe it hands over the whole line setup: the function byte, the first in-word bit position, the channel enables, the error term with its sign and its two increments, the row pitch, the pointers and the A data. The block then produces one destination word for every pixel strobe. It combines an A word, a one-bit B texture and a C word through an 8-bit minterm, and it marks whether that word must be stored. After each pixel it advances the Bresenham error term and steps the in-word position and the C pointer along the major and minor axes.

The octant is decoded outside the block. The block is told only which axis is major and which way each axis runs. It does not touch memory and does not schedule cycles. Any B or C word read by the sequencer is presented on an input together with the pixel strobe, and a store request comes back one cycle later with its address. When the sequencer signals the end of the line, the block shows, for a single cycle, the final in-word position, sign, error term (merged into the A pointer), and the B, C and D pointers, so that they can be written back to the visible registers. A zero flag reports whether every minterm result of the line was zero.

The control is a three-state machine. `LP_IDLE` waits for work, `LP_RUN` accepts pixel strobes, and `LP_WBACK` presents the write-back values for one cycle. Its transitions are: `LP_IDLE` to `LP_RUN` on `start`; `LP_RUN` to `LP_WBACK` on `done_stb`; `LP_WBACK` to `LP_IDLE` unconditionally. In every other case the machine stays in its state.

Top module: `lp_line_pixel`

## Requirements
- R1: A `start` in `LP_IDLE` latches the line setup, loads `dpt` with `cpt_init`, sets `zero_flag` and makes `busy` high from the next cycle. After reset `busy`, `st_vld` and `wb_vld` are 0 and `zero_flag` is 1.
- R2: The A operand of a pixel is (`a_data` AND `fwm`), latched at start, shifted right by the current in-word position.
- R3: The B operand is all ones when bit 0 of the texture is 1, and all zeros otherwise. The texture is the source word rotated right by the `b_shift` present at the pixel strobe. The source word is `b_fetch` when `use_b` is set and `b_data` otherwise. With `use_b` set, each pixel adds the sign-extended `bmod` to the B pointer.
- R4: Bit i of the result is bit {A[i],B[i],C[i]} of `fn_byte`, where A is the index MSB.
- R5: With `use_a` set, each pixel adds `bmod` to the 16-bit error term when the sign is 1, and `amod` when it is 0. The new sign is bit 15 of the sum.
- R6: With `use_a` clear, the error term and the sign keep their start values for the whole line.
- R7: The major axis steps on every pixel. The minor axis steps only when the sign is 0 before the update. An X step moves the in-word position by one, up or down according to `x_neg`. When the position wraps (15 to 0 going up, 0 to 15 going down), the C pointer moves 2 bytes in the same direction. A Y step adds or subtracts the sign-extended `row_mod` according to `y_neg`.
- R8: One cycle after a pixel strobe, `st_vld` is high if the pixel is stored, `st_addr` holds the C pointer from before the step, and `st_data` holds the result. The D pointer takes that address on every pixel.
- R9: With `sing` set, only the first pixel after start or after a Y step is stored. Suppressed pixels still update the position, the error term and the zero flag.
- R10: With `use_c` set, the C word is `c_fetch` and it is also loaded into the C data register. With `use_c` clear, the C word is that register. The register keeps its value across lines, and `cdat_wr` writes it outside pixel strobes.
- R11: `zero_flag` clears when any pixel result, stored or not, is nonzero, and it stays clear until the next start.
- R12: `done_stb` in `LP_RUN` gives exactly one cycle of `wb_vld`, showing the in-word position, the sign, the A pointer (start high bits with the error term in the low 16 bits), and the B, C and D pointers. The machine is idle on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a line, latch setup |
| fn_byte | input | 8 | Minterm function byte |
| ash_init | input | 4 | Initial in-word bit position |
| use_a | input | 1 | Channel A enable (error term advance) |
| use_b | input | 1 | Channel B enable (texture from fetch) |
| use_c | input | 1 | Channel C enable (C word from fetch) |
| sing | input | 1 | Store only the first pixel per row |
| major_x | input | 1 | Major axis is X |
| x_neg | input | 1 | X steps towards lower positions |
| y_neg | input | 1 | Y steps subtract the row pitch |
| acc_init | input | 16 | Initial error term |
| sign_init | input | 1 | Initial sign |
| amod | input | 16 | Error increment while sign is 0 |
| bmod | input | 16 | Error increment while sign is 1, B pointer step |
| row_mod | input | 16 | Signed row pitch in bytes |
| apt_init | input | 24 | A pointer (high bits kept) |
| bpt_init | input | 24 | Initial B pointer |
| cpt_init | input | 24 | Initial C pointer |
| a_data | input | 16 | A data word |
| fwm | input | 16 | First-word mask |
| pix_stb | input | 1 | Compute one pixel |
| b_shift | input | 4 | Live B rotate amount |
| b_data | input | 16 | B data register value |
| b_fetch | input | 16 | B word fetched for this pixel |
| c_fetch | input | 16 | C word fetched for this pixel |
| cdat_wr | input | 1 | Write the C data register |
| cdat_wdata | input | 16 | Value for the C data register |
| done_stb | input | 1 | End of line |
| busy | output | 1 | Line open or write-back pending |
| zero_flag | output | 1 | All results of the line zero |
| st_vld | output | 1 | Store request |
| st_addr | output | 24 | Store address |
| st_data | output | 16 | Store data |
| wb_vld | output | 1 | Write-back values valid |
| wb_ash | output | 4 | Final in-word position |
| wb_sign | output | 1 | Final sign |
| wb_apt | output | 24 | A pointer with error term in low bits |
| wb_bpt | output | 24 | Final B pointer |
| wb_cpt | output | 24 | Final C pointer |
| wb_dpt | output | 24 | Final D pointer |

## Verification
The checker watches a set of rules on every cycle: that a start produces busy and a set zero flag, that the error term is frozen both between pixels and for a whole line with A disabled, that the zero flag never sets again without a start, that a store request only follows a pixel strobe in `LP_RUN`, and that write-back lasts a single cycle before idle. The values themselves can only be shown by the bench scenarios. These cover the minterm results, the live B rotation, the wrap of the in-word position into the C pointer, single-dot suppression that still clears the zero flag, and a C word carried from one line into the next. A reference model in the bench computes them from randomized and directed lines.

// File: rtl/lp_pkg.sv
package lp_pkg;
    typedef enum logic [1:0] {
        LP_IDLE  = 2'd0,
        LP_RUN   = 2'd1,
        LP_WBACK = 2'd2
    } lp_state_e;
endpackage

// File: rtl/lp_minterm.sv
module lp_minterm #(
    parameter int DW = 16
) (
    input  logic [7:0]    fn,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic [DW-1:0] c_in,
    output logic [DW-1:0] d_out
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign d_out[i] = fn[{a_in[i], b_in[i], c_in[i]}];
    end
endmodule

// File: rtl/lp_axis_step.sv
module lp_axis_step #(
    parameter int DW = 16,
    parameter int AW = 24,
    localparam int SW = $clog2(DW),
    localparam int BYTES = DW / 8
) (
    input  logic [SW-1:0] ash,
    input  logic [AW-1:0] cpt,
    input  logic [DW-1:0] row_mod,
    input  logic          step_x,
    input  logic          step_y,
    input  logic          x_neg,
    input  logic          y_neg,
    output logic [SW-1:0] ash_nx,
    output logic [AW-1:0] cpt_nx
);
    localparam logic [SW-1:0] POS_MAX = SW'(DW - 1);
    logic [AW-1:0] dx;
    logic [AW-1:0] dy;
    logic [AW-1:0] row_ext;

    assign row_ext = {{(AW-DW){row_mod[DW-1]}}, row_mod};

    always_comb begin
        ash_nx = ash;
        dx     = '0;
        if (step_x) begin
            if (x_neg) begin
                if (ash == '0) begin
                    ash_nx = POS_MAX;
                    dx     = AW'(0) - AW'(BYTES);
                end else begin
                    ash_nx = ash - SW'(1);
                end
            end else begin
                if (ash == POS_MAX) begin
                    ash_nx = '0;
                    dx     = AW'(BYTES);
                end else begin
                    ash_nx = ash + SW'(1);
                end
            end
        end
        dy = '0;
        if (step_y) begin
            dy = y_neg ? (AW'(0) - row_ext) : row_ext;
        end
        cpt_nx = cpt + dx + dy;
    end
endmodule

// File: rtl/lp_err_acc.sv
module lp_err_acc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] acc_init,
    input  logic          sign_init,
    input  logic          adv,
    input  logic [DW-1:0] inc_pos,
    input  logic [DW-1:0] inc_neg,
    output logic [DW-1:0] acc,
    output logic          sign
);
    logic [DW-1:0] sum;
    assign sum = acc + (sign ? inc_neg : inc_pos);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            sign <= 1'b0;
        end else if (load) begin
            acc  <= acc_init;
            sign <= sign_init;
        end else if (adv) begin
            acc  <= sum;
            sign <= sum[DW-1];
        end
    end
endmodule

// File: rtl/lp_line_pixel.sv
module lp_line_pixel
    import lp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 24,
    localparam int SW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    fn_byte,
    input  logic [SW-1:0] ash_init,
    input  logic          use_a,
    input  logic          use_b,
    input  logic          use_c,
    input  logic          sing,
    input  logic          major_x,
    input  logic          x_neg,
    input  logic          y_neg,
    input  logic [DW-1:0] acc_init,
    input  logic          sign_init,
    input  logic [DW-1:0] amod,
    input  logic [DW-1:0] bmod,
    input  logic [DW-1:0] row_mod,
    input  logic [AW-1:0] apt_init,
    input  logic [AW-1:0] bpt_init,
    input  logic [AW-1:0] cpt_init,
    input  logic [DW-1:0] a_data,
    input  logic [DW-1:0] fwm,
    input  logic          pix_stb,
    input  logic [SW-1:0] b_shift,
    input  logic [DW-1:0] b_data,
    input  logic [DW-1:0] b_fetch,
    input  logic [DW-1:0] c_fetch,
    input  logic          cdat_wr,
    input  logic [DW-1:0] cdat_wdata,
    input  logic          done_stb,
    output logic          busy,
    output logic          zero_flag,
    output logic          st_vld,
    output logic [AW-1:0] st_addr,
    output logic [DW-1:0] st_data,
    output logic          wb_vld,
    output logic [SW-1:0] wb_ash,
    output logic          wb_sign,
    output logic [AW-1:0] wb_apt,
    output logic [AW-1:0] wb_bpt,
    output logic [AW-1:0] wb_cpt,
    output logic [AW-1:0] wb_dpt
);
    lp_state_e state_q, state_d;

    logic [7:0]       fn_q;
    logic [SW-1:0]    ash_q;
    logic             use_a_q, use_b_q, use_c_q, sing_q;
    logic             major_x_q, x_neg_q, y_neg_q;
    logic [DW-1:0]    amod_q, bmod_q, row_mod_q, a_word_q, c_reg;
    logic [AW-DW-1:0] apt_hi_q;
    logic [AW-1:0]    bpt_q, cpt_q, dpt_q;
    logic             one_dot_q, zero_q;
    logic             st_vld_q;
    logic [AW-1:0]    st_addr_q;
    logic [DW-1:0]    st_data_q;

    logic             load, fire, store_ok, step_x, step_y;
    logic [DW-1:0]    a_in, b_in, c_in, d_w, b_src;
    logic [2*DW-1:0]  b_dbl;
    logic [DW-1:0]    acc_w;
    logic             sign_w;
    logic [SW-1:0]    ash_nx;
    logic [AW-1:0]    cpt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_IDLE:  if (start)    state_d = LP_RUN;
            LP_RUN:   if (done_stb) state_d = LP_WBACK;
            LP_WBACK:               state_d = LP_IDLE;
            default:                state_d = LP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != LP_IDLE);
        wb_vld    = (state_q == LP_WBACK);
        zero_flag = zero_q;
        st_vld    = st_vld_q;
        st_addr   = st_addr_q;
        st_data   = st_data_q;
        wb_ash    = ash_q;
        wb_sign   = sign_w;
        wb_apt    = {apt_hi_q, acc_w};
        wb_bpt    = bpt_q;
        wb_cpt    = cpt_q;
        wb_dpt    = dpt_q;
    end

    assign load     = start && (state_q == LP_IDLE);
    assign fire     = pix_stb && (state_q == LP_RUN);
    assign store_ok = !sing_q || !one_dot_q;

    // operand formation
    assign a_in  = a_word_q >> ash_q;
    assign b_src = use_b_q ? b_fetch : b_data;
    assign b_dbl = {b_src, b_src} >> b_shift;
    assign b_in  = {DW{b_dbl[0]}};
    assign c_in  = use_c_q ? c_fetch : c_reg;

    // major axis always, minor axis on a clear sign
    assign step_x = major_x_q ? 1'b1 : !sign_w;
    assign step_y = major_x_q ? !sign_w : 1'b1;

    lp_minterm #(.DW(DW)) u_mint (
        .fn(fn_q), .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_out(d_w)
    );

    lp_axis_step #(.DW(DW), .AW(AW)) u_step (
        .ash(ash_q), .cpt(cpt_q), .row_mod(row_mod_q),
        .step_x(step_x), .step_y(step_y), .x_neg(x_neg_q), .y_neg(y_neg_q),
        .ash_nx(ash_nx), .cpt_nx(cpt_nx)
    );

    lp_err_acc #(.DW(DW)) u_err (
        .clk(clk), .rst_n(rst_n), .load(load),
        .acc_init(acc_init), .sign_init(sign_init),
        .adv(fire && use_a_q), .inc_pos(amod_q), .inc_neg(bmod_q),
        .acc(acc_w), .sign(sign_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fn_q <= '0; ash_q <= '0;
            use_a_q <= 1'b0; use_b_q <= 1'b0; use_c_q <= 1'b0; sing_q <= 1'b0;
            major_x_q <= 1'b0; x_neg_q <= 1'b0; y_neg_q <= 1'b0;
            amod_q <= '0; bmod_q <= '0; row_mod_q <= '0; a_word_q <= '0;
            apt_hi_q <= '0; bpt_q <= '0; cpt_q <= '0; dpt_q <= '0;
            c_reg <= '0; one_dot_q <= 1'b0; zero_q <= 1'b1;
            st_vld_q <= 1'b0; st_addr_q <= '0; st_data_q <= '0;
        end else begin
            st_vld_q <= fire && store_ok;
            if (load) begin
                fn_q <= fn_byte; ash_q <= ash_init;
                use_a_q <= use_a; use_b_q <= use_b; use_c_q <= use_c;
                sing_q <= sing; major_x_q <= major_x;
                x_neg_q <= x_neg; y_neg_q <= y_neg;
                amod_q <= amod; bmod_q <= bmod; row_mod_q <= row_mod;
                a_word_q <= a_data & fwm;
                apt_hi_q <= apt_init[AW-1:DW];
                bpt_q <= bpt_init; cpt_q <= cpt_init; dpt_q <= cpt_init;
                one_dot_q <= 1'b0; zero_q <= 1'b1;
            end else if (fire) begin
                st_addr_q <= cpt_q;
                st_data_q <= d_w;
                dpt_q     <= cpt_q;
                ash_q     <= ash_nx;
                cpt_q     <= cpt_nx;
                one_dot_q <= !step_y;
                if (d_w != '0) zero_q <= 1'b0;
                if (use_b_q) bpt_q <= bpt_q + {{(AW-DW){bmod_q[DW-1]}}, bmod_q};
            end
            if (fire && use_c_q)  c_reg <= c_fetch;
            else if (cdat_wr)     c_reg <= cdat_wdata;
        end
    end
endmodule

module lp_line_pixel_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          pix_stb,
    input logic          zero_flag,
    input logic          st_vld,
    input logic          wb_vld,
    input logic          use_a,
    input logic          sign,
    input logic [DW-1:0] acc
);
    // R1
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && zero_flag));

    // R6
    sign_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_a && !(start && !busy)) |=> ($stable(sign) && $stable(acc)));

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_stb && !(start && !busy)) |=> ($stable(acc) && $stable(sign)));

    // R8
    store_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_vld |-> $past(pix_stb && busy && !wb_vld));

    // R11
    zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_flag && !(start && !busy)) |=> !zero_flag);

    // R12
    wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |=> (!wb_vld && !busy));
endmodule

bind lp_line_pixel lp_line_pixel_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .pix_stb(pix_stb), .zero_flag(zero_flag), .st_vld(st_vld),
    .wb_vld(wb_vld), .use_a(use_a_q), .sign(sign_w), .acc(acc_w)
);

// File: tb/lp_line_pixel_bench.sv
`timescale 1ns/1ps
module lp_line_pixel_bench;
    logic clk = 1'b0;
    logic rst_n;
    always #2.5 clk = ~clk;

    logic start, use_a, use_b, use_c, sing, major_x, x_neg, y_neg, sign_init;
    logic [7:0] fn_byte;
    logic [3:0] ash_init, b_shift;
    logic [15:0] acc_init, amod, bmod, row_mod, a_data, fwm, b_data, b_fetch, c_fetch, cdat_wdata;
    logic [23:0] apt_init, bpt_init, cpt_init;
    logic pix_stb, cdat_wr, done_stb;
    logic busy, zero_flag, st_vld, wb_vld, wb_sign;
    logic [23:0] st_addr, wb_apt, wb_bpt, wb_cpt, wb_dpt;
    logic [15:0] st_data;
    logic [3:0] wb_ash;

    lp_line_pixel u_lp_line_pixel (.*);

    int checks = 0, fails = 0;
    logic [3:0]  m_ash;
    logic [15:0] m_acc, m_aword, m_creg, m_last;
    logic        m_sign, m_onedot, m_zero;
    logic [23:0] m_cpt, m_bpt, m_dpt;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] sx(input logic [15:0] v);
        return {{8{v[15]}}, v};
    endfunction

    task automatic begin_line();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_ash = ash_init; m_acc = acc_init; m_sign = sign_init;
        m_aword = a_data & fwm; m_cpt = cpt_init; m_bpt = bpt_init;
        m_dpt = cpt_init; m_onedot = 1'b0; m_zero = 1'b1;
        chk(busy === 1'b1 && zero_flag === 1'b1, "R1 start", {busy, zero_flag}, 2'b11);
    endtask

    task automatic pixel();
        logic [15:0] a, b, c, d, bs;
        logic [31:0] dbl;
        logic st, sxs, sys;
        bs  = use_b ? b_fetch : b_data;
        dbl = {bs, bs} >> b_shift;
        a = m_aword >> m_ash;
        b = {16{dbl[0]}};
        c = use_c ? c_fetch : m_creg;
        for (int i = 0; i < 16; i++) d[i] = fn_byte[{a[i], b[i], c[i]}];
        st = !sing || !m_onedot;
        pix_stb = 1'b1;
        @(negedge clk);
        pix_stb = 1'b0;
        chk(st_vld === st, "R8/R9 store strobe", st_vld, st);
        if (st) begin
            chk(st_data === d, "R4 store data", st_data, d);
            chk(st_addr === m_cpt, "R8 store address", st_addr, m_cpt);
        end
        m_last = st_data;
        if (use_c) m_creg = c_fetch;
        if (d != 0) m_zero = 1'b0;
        chk(zero_flag === m_zero, "R11 zero flag", zero_flag, m_zero);
        sxs = major_x ? 1'b1 : !m_sign;
        sys = major_x ? !m_sign : 1'b1;
        m_dpt = m_cpt;
        if (sxs) begin
            if (x_neg) begin
                if (m_ash == 0) m_cpt = m_cpt - 24'd2;
                m_ash = m_ash - 4'd1;
            end else begin
                if (m_ash == 15) m_cpt = m_cpt + 24'd2;
                m_ash = m_ash + 4'd1;
            end
        end
        if (sys) m_cpt = y_neg ? m_cpt - sx(row_mod) : m_cpt + sx(row_mod);
        m_onedot = !sys;
        if (use_a) begin
            m_acc = m_acc + (m_sign ? bmod : amod);
            m_sign = m_acc[15];
        end
        if (use_b) m_bpt = m_bpt + sx(bmod);
    endtask

    task automatic end_line();
        done_stb = 1'b1;
        @(negedge clk);
        done_stb = 1'b0;
        chk(wb_vld === 1'b1, "R12 write-back strobe", wb_vld, 1);
        chk(wb_ash === m_ash, "R7 final position", wb_ash, m_ash);
        chk(wb_sign === m_sign, "R5 final sign", wb_sign, m_sign);
        chk(wb_apt === {apt_init[23:16], m_acc}, "R5 error term in A pointer", wb_apt, {apt_init[23:16], m_acc});
        chk(wb_bpt === m_bpt, "R3 B pointer", wb_bpt, m_bpt);
        chk(wb_cpt === m_cpt, "R7 C pointer", wb_cpt, m_cpt);
        chk(wb_dpt === m_dpt, "R12 D pointer", wb_dpt, m_dpt);
        @(negedge clk);
        chk(wb_vld === 1'b0 && busy === 1'b0, "R12 back to idle", {wb_vld, busy}, 0);
    endtask

    task automatic rand_setup();
        fn_byte = 8'($urandom); ash_init = 4'($urandom);
        use_a = 1'($urandom); use_b = 1'($urandom); use_c = 1'($urandom);
        sing = 1'($urandom); major_x = 1'($urandom);
        x_neg = 1'($urandom); y_neg = 1'($urandom);
        acc_init = 16'($urandom); sign_init = 1'($urandom);
        amod = 16'($urandom); bmod = 16'($urandom); row_mod = 16'($urandom);
        apt_init = 24'($urandom); bpt_init = 24'($urandom); cpt_init = 24'($urandom);
        a_data = 16'($urandom); fwm = 16'($urandom);
    endtask

    task automatic rand_pix();
        b_shift = 4'($urandom); b_data = 16'($urandom);
        b_fetch = 16'($urandom); c_fetch = 16'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 0; pix_stb = 0; cdat_wr = 0; done_stb = 0; cdat_wdata = 0;
        rand_setup(); rand_pix();
        m_creg = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 0 && st_vld === 0 && wb_vld === 0 && zero_flag === 1, "R1 reset state",
            {busy, st_vld, wb_vld, zero_flag}, 4'b0001);

        // R2/R9: A output only, single dot, minor axis never steps
        rand_setup();
        fn_byte = 8'hF0; a_data = 16'h0001; fwm = 16'hFFFF; ash_init = 4'd15;
        use_a = 0; sign_init = 1; sing = 1; major_x = 1; x_neg = 0; use_b = 0; use_c = 0;
        begin_line();
        rand_pix(); pixel();
        chk(zero_flag === 1'b1, "R2 first dot A shifted out", zero_flag, 1);
        rand_pix(); pixel();
        chk(st_vld === 1'b0 && zero_flag === 1'b0, "R9 suppressed dot clears zero",
            {st_vld, zero_flag}, 2'b00);
        end_line();
        chk(wb_sign === 1'b1 && wb_apt[15:0] === acc_init, "R6 error term frozen",
            {wb_sign, wb_apt[15:0]}, {1'b1, acc_init});
        chk(wb_cpt === cpt_init + 24'd2, "R7 position wrap moves C pointer", wb_cpt, cpt_init + 24'd2);

        // R3: live B rotate amount, texture from b_data
        rand_setup();
        fn_byte = 8'hCC; use_b = 0; sing = 0;
        begin_line();
        b_data = 16'h0002; b_shift = 4'd0; pixel();
        chk(m_last === 16'h0000, "R3 texture bit clear", m_last, 0);
        b_shift = 4'd1; pixel();
        chk(m_last === 16'hFFFF, "R3 live rotate picks bit", m_last, 16'hFFFF);
        end_line();

        // R10: fetched C word carried into a later line
        rand_setup();
        use_c = 1; sing = 0;
        begin_line();
        rand_pix(); pixel();
        c_fetch = 16'h1234; pixel();
        end_line();
        rand_setup();
        use_c = 0; sing = 0; fn_byte = 8'hAA;
        begin_line();
        rand_pix(); pixel();
        chk(m_last === 16'h1234, "R10 C register carries fetch", m_last, 16'h1234);
        end_line();

        // R10: software write of the C register
        @(negedge clk);
        cdat_wr = 1; cdat_wdata = 16'hBEEF; m_creg = 16'hBEEF;
        @(negedge clk);
        cdat_wr = 0;
        rand_setup();
        use_c = 0; sing = 0; fn_byte = 8'hAA;
        begin_line();
        rand_pix(); pixel();
        chk(m_last === 16'hBEEF, "R10 C register write", m_last, 16'hBEEF);
        end_line();

        // random lines
        for (int ln = 0; ln < 60; ln++) begin
            rand_setup();
            begin_line();
            for (int p = 0; p < 1 + int'($urandom % 14); p++) begin
                rand_pix();
                pixel();
            end
            end_line();
            if ($urandom % 4 == 0) begin
                cdat_wr = 1; cdat_wdata = 16'($urandom); m_creg = cdat_wdata;
                @(negedge clk);
                cdat_wr = 0;
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule